// File: doc/BRIEF.md
# Sleep Mode and Wake Sequencer

This block is the low-power state controller of a small microcontroller core. Software loads a configuration word with a 2-bit sleep depth, a sleep-permit bit and a brown-out sleep-off bit. A one-cycle sleep request strobe then moves the controller out of its running state into the selected depth. While it sleeps, it drives gate enables for the CPU, I/O, flash and ADC clock domains, an enable for the main oscillator and an enable for the brown-out detector. While the core runs, every enable is high.

Every sleep depth accepts its own set of wake sources. Sources outside that set are ignored. The three reset-class sources wake the core from any depth and also pulse a core reset output. The exit from sleep depends on the depth. The two shallow depths resume on the next cycle. Standby counts a fixed number of cycles. Power-down restarts the oscillator and waits for its ready handshake. If the brown-out detector was switched off for the sleep, a longer settling count is added before the CPU clock returns. The oscillator, the brown-out detector and the ADC sit outside the block and connect through plain enable and handshake signals.

Top module: `lowpwr_ctrl`

States: RUN (core active), DOZE (asleep in the latched depth), OSC (oscillator restarting), HOLD (settling count). Transitions:
- RUN to DOZE on a permitted request.
- DOZE to RUN on an eligible wake in the shallow depths.
- DOZE to OSC on an eligible wake in Power-down.
- DOZE to HOLD on an eligible wake in Standby.
- OSC to HOLD, or OSC to RUN, on oscillator ready.
- HOLD to RUN when the count expires.

## Requirements
- R1: After reset, and whenever the CPU clock enable is high, all five clock and oscillator enables and bod_en are 1; adc_start and core_rst are 0.
- R2: cfg_wr loads cfg_mode, cfg_sleep_en and cfg_bod_off. Depth encoding: 00 Idle, 01 ADC-quiet, 10 Power-down, 11 Standby. A sleep_req while the stored sleep-permit bit is 0 has no effect, and the CPU clock stays enabled.
- R3: Idle is entered on the cycle after an accepted request. In Idle, only clk_cpu_en is 0. Any of the nine wake inputs re-enables the CPU clock on the cycle after the edge that samples it.
- R4: In ADC-quiet, the CPU, I/O and flash enables are 0 and the ADC and oscillator enables are 1. Only wk_adc_done, wk_nvm_rdy, wk_int0, wk_pin_chg and the reset-class inputs wake the core. wk_irq_int and wk_irq_ext are ignored.
- R5: adc_start is a single-cycle pulse in the first sleeping cycle. It occurs only on entry to Idle or ADC-quiet, and only with adc_on high.
- R6: In Power-down, every clock enable and osc_en are 0. Only wk_int0, wk_pin_chg and the reset-class inputs wake the core.
- R7: On a Power-down wake, osc_en is 1 from the next cycle while all clocks stay off. Clocks return on the cycle after osc_ready is sampled high.
- R8: In Standby, which needs xtal_sel high at entry, osc_en stays 1 and all clock enables are 0. The CPU clock returns STBY_CYC cycles after the wake edge.
- R9: A Standby request made with xtal_sel low behaves exactly as Power-down.
- R10: With cfg_bod_off set, bod_en is 0 while asleep in Power-down or Standby. It stays 1 in Idle and ADC-quiet, and returns to 1 on the cycle after the wake edge.
- R11: When the brown-out detector was off, the CPU clock returns BOD_CYC cycles after the wake edge in Standby, or BOD_CYC cycles after osc_ready is sampled in Power-down.
- R12: A wake by wk_rst_ext, wk_rst_wdt or wk_rst_bod raises core_rst for exactly the cycle after the wake edge. Interrupt wakes leave core_rst at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_mode | input | 2 | Sleep depth to store |
| cfg_sleep_en | input | 1 | Sleep-permit bit to store |
| cfg_bod_off | input | 1 | Brown-out off during deep sleep |
| sleep_req | input | 1 | Sleep request strobe |
| xtal_sel | input | 1 | External crystal clock option selected |
| adc_on | input | 1 | ADC enabled |
| osc_ready | input | 1 | Oscillator stable handshake |
| wk_irq_int | input | 1 | Internal interrupt (timer and similar) |
| wk_irq_ext | input | 1 | Other external edge interrupt |
| wk_int0 | input | 1 | Level interrupt on external pin 0 |
| wk_pin_chg | input | 1 | Pin-change interrupt |
| wk_adc_done | input | 1 | ADC conversion complete |
| wk_nvm_rdy | input | 1 | Flash/EEPROM write ready |
| wk_rst_ext | input | 1 | External reset request |
| wk_rst_wdt | input | 1 | Watchdog reset request |
| wk_rst_bod | input | 1 | Brown-out reset request |
| clk_cpu_en | output | 1 | CPU clock gate enable |
| clk_io_en | output | 1 | I/O clock gate enable |
| clk_flash_en | output | 1 | Flash clock gate enable |
| clk_adc_en | output | 1 | ADC clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| bod_en | output | 1 | Brown-out detector enable |
| adc_start | output | 1 | Start-conversion pulse |
| core_rst | output | 1 | Core reset pulse on reset-class wake |

## Verification
The hardest condition to reach is the long settling path. It needs a brown-out-off configuration, Power-down or Standby with the crystal option set, a wake on a source eligible in that depth, and, in Power-down, a late osc_ready. The stimulus sets up each of these in turn, holds osc_ready low for several cycles, and counts cycles from the wake or ready edge to the return of the CPU clock. Ineligible wake inputs are pulsed in each depth first, so that a filter that is too loose shows as an early clock return.

// File: rtl/lowpwr_pkg.sv
package lowpwr_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCQ  = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_STBY  = 2'b11
    } lp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DOZE,
        ST_OSC,
        ST_HOLD
    } lp_state_e;

    typedef struct packed {
        logic irq_int;
        logic irq_ext;
        logic int0;
        logic pin_chg;
        logic adc_done;
        logic nvm_rdy;
        logic rst_ext;
        logic rst_wdt;
        logic rst_bod;
    } lp_wake_t;

endpackage

// File: rtl/lowpwr_cfg.sv
module lowpwr_cfg
    import lowpwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  logic [1:0] mode_in,
    input  logic     sen_in,
    input  logic     bod_in,
    output lp_mode_e mode_q,
    output logic     sen_q,
    output logic     bodoff_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_IDLE;
            sen_q    <= 1'b0;
            bodoff_q <= 1'b0;
        end else if (wr) begin
            mode_q   <= lp_mode_e'(mode_in);
            sen_q    <= sen_in;
            bodoff_q <= bod_in;
        end
    end
endmodule

// File: rtl/lowpwr_wake_filt.sv
module lowpwr_wake_filt
    import lowpwr_pkg::*;
(
    input  lp_mode_e mode,
    input  lp_wake_t src,
    output logic     wake,
    output logic     rst_any
);
    lp_wake_t allow;

    // Each depth admits its own subset of sources; reset-class always admitted.
    always_comb begin
        allow = '0;
        allow.rst_ext = 1'b1;
        allow.rst_wdt = 1'b1;
        allow.rst_bod = 1'b1;
        allow.int0    = 1'b1;
        allow.pin_chg = 1'b1;
        unique case (mode)
            MODE_IDLE: begin
                allow.irq_int  = 1'b1;
                allow.irq_ext  = 1'b1;
                allow.adc_done = 1'b1;
                allow.nvm_rdy  = 1'b1;
            end
            MODE_ADCQ: begin
                allow.adc_done = 1'b1;
                allow.nvm_rdy  = 1'b1;
            end
            MODE_PDOWN, MODE_STBY: begin
            end
            default: begin
            end
        endcase
    end

    assign wake    = |(src & allow);
    assign rst_any = src.rst_ext | src.rst_wdt | src.rst_bod;
endmodule

// File: rtl/lowpwr_dly.sv
module lowpwr_dly #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
    import lowpwr_pkg::*;
#(
    parameter int STBY_CYC = 6,
    parameter int BOD_CYC  = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_sleep_en,
    input  logic       cfg_bod_off,
    input  logic       sleep_req,
    input  logic       xtal_sel,
    input  logic       adc_on,
    input  logic       osc_ready,
    input  logic       wk_irq_int,
    input  logic       wk_irq_ext,
    input  logic       wk_int0,
    input  logic       wk_pin_chg,
    input  logic       wk_adc_done,
    input  logic       wk_nvm_rdy,
    input  logic       wk_rst_ext,
    input  logic       wk_rst_wdt,
    input  logic       wk_rst_bod,
    output logic       clk_cpu_en,
    output logic       clk_io_en,
    output logic       clk_flash_en,
    output logic       clk_adc_en,
    output logic       osc_en,
    output logic       bod_en,
    output logic       adc_start,
    output logic       core_rst
);
    localparam int DLY_MAX = (BOD_CYC > STBY_CYC) ? BOD_CYC : STBY_CYC;
    localparam int CW      = $clog2(DLY_MAX + 1);
    localparam logic [CW-1:0] BOD_V  = CW'(BOD_CYC);
    localparam logic [CW-1:0] STBY_V = CW'(STBY_CYC);

    lp_state_e state_q, state_d;
    lp_mode_e  cfg_mode_q, slp_mode_q, eff_mode;
    logic      cfg_sen_q, cfg_bod_q, slp_bod_q;
    logic      wake_hit, rst_any, enter;
    logic      dly_load, dly_last;
    logic [CW-1:0] dly_val;
    logic      adc_start_q, core_rst_q;
    lp_wake_t  src;

    lowpwr_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .mode_in  (cfg_mode),
        .sen_in   (cfg_sleep_en),
        .bod_in   (cfg_bod_off),
        .mode_q   (cfg_mode_q),
        .sen_q    (cfg_sen_q),
        .bodoff_q (cfg_bod_q)
    );

    assign src = '{irq_int: wk_irq_int, irq_ext: wk_irq_ext, int0: wk_int0,
                   pin_chg: wk_pin_chg, adc_done: wk_adc_done, nvm_rdy: wk_nvm_rdy,
                   rst_ext: wk_rst_ext, rst_wdt: wk_rst_wdt, rst_bod: wk_rst_bod};

    lowpwr_wake_filt u_filt (
        .mode    (slp_mode_q),
        .src     (src),
        .wake    (wake_hit),
        .rst_any (rst_any)
    );

    lowpwr_dly #(.W(CW)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dly_load),
        .val   (dly_val),
        .last  (dly_last)
    );

    // Standby without the crystal option degrades to Power-down.
    assign eff_mode = (cfg_mode_q == MODE_STBY && !xtal_sel) ? MODE_PDOWN : cfg_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_mode_q  <= MODE_IDLE;
            slp_bod_q   <= 1'b0;
            adc_start_q <= 1'b0;
            core_rst_q  <= 1'b0;
        end else begin
            if (enter) begin
                slp_mode_q <= eff_mode;
                slp_bod_q  <= cfg_bod_q && eff_mode[1];
            end
            adc_start_q <= enter && adc_on && !eff_mode[1];
            core_rst_q  <= (state_q == ST_DOZE) && rst_any;
        end
    end

    always_comb begin
        state_d  = state_q;
        enter    = 1'b0;
        dly_load = 1'b0;
        dly_val  = '0;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_req && cfg_sen_q) begin
                    state_d = ST_DOZE;
                    enter   = 1'b1;
                end
            end
            ST_DOZE: begin
                if (wake_hit) begin
                    unique case (slp_mode_q)
                        MODE_IDLE, MODE_ADCQ: state_d = ST_RUN;
                        MODE_PDOWN:           state_d = ST_OSC;
                        MODE_STBY: begin
                            state_d  = ST_HOLD;
                            dly_load = 1'b1;
                            dly_val  = slp_bod_q ? BOD_V : STBY_V;
                        end
                        default:              state_d = ST_RUN;
                    endcase
                end
            end
            ST_OSC: begin
                if (osc_ready) begin
                    if (slp_bod_q) begin
                        state_d  = ST_HOLD;
                        dly_load = 1'b1;
                        dly_val  = BOD_V;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_HOLD: begin
                if (dly_last)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        clk_cpu_en   = 1'b0;
        clk_io_en    = 1'b0;
        clk_flash_en = 1'b0;
        clk_adc_en   = 1'b0;
        osc_en       = 1'b1;
        bod_en       = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                clk_cpu_en   = 1'b1;
                clk_io_en    = 1'b1;
                clk_flash_en = 1'b1;
                clk_adc_en   = 1'b1;
            end
            ST_DOZE: begin
                bod_en = !slp_bod_q;
                unique case (slp_mode_q)
                    MODE_IDLE: begin
                        clk_io_en    = 1'b1;
                        clk_flash_en = 1'b1;
                        clk_adc_en   = 1'b1;
                    end
                    MODE_ADCQ:  clk_adc_en = 1'b1;
                    MODE_PDOWN: osc_en     = 1'b0;
                    MODE_STBY:  osc_en     = 1'b1;
                    default:    osc_en     = 1'b1;
                endcase
            end
            ST_OSC, ST_HOLD: begin
            end
            default: begin
            end
        endcase
    end

    assign adc_start = adc_start_q;
    assign core_rst  = core_rst_q;
endmodule

// File: rtl/lowpwr_ctrl_chk.sv
module lowpwr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic clk_cpu_en,
    input logic clk_io_en,
    input logic clk_flash_en,
    input logic clk_adc_en,
    input logic osc_en,
    input logic bod_en,
    input logic adc_start,
    input logic core_rst
);
    AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        clk_cpu_en |-> (clk_io_en && clk_flash_en && clk_adc_en && osc_en && bod_en)); // R1

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_cpu_en && !sleep_req) |=> clk_cpu_en); // R2

    AST_ADC_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (!clk_cpu_en && clk_adc_en)); // R5

    AST_ADC_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R5

    AST_OSC_OFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !(clk_io_en || clk_flash_en || clk_adc_en)); // R6

    AST_NO_DIRECT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !clk_cpu_en); // R7

    AST_BOD_OFF_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !bod_en |-> (!clk_adc_en && !clk_cpu_en)); // R10

    AST_CORE_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst); // R12
endmodule

bind lowpwr_ctrl lowpwr_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .clk_cpu_en   (clk_cpu_en),
    .clk_io_en    (clk_io_en),
    .clk_flash_en (clk_flash_en),
    .clk_adc_en   (clk_adc_en),
    .osc_en       (osc_en),
    .bod_en       (bod_en),
    .adc_start    (adc_start),
    .core_rst     (core_rst)
);

// File: tb/lowpwr_ctrl_bench.sv
`timescale 1ns/1ps
module lowpwr_ctrl_bench;
    localparam int STBY = 6;
    localparam int BODC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_sleep_en = 0, cfg_bod_off = 0, sleep_req = 0;
    logic [1:0] cfg_mode = 2'b00;
    logic xtal_sel = 0, adc_on = 0, osc_ready = 0;
    logic wk_irq_int = 0, wk_irq_ext = 0, wk_int0 = 0, wk_pin_chg = 0;
    logic wk_adc_done = 0, wk_nvm_rdy = 0, wk_rst_ext = 0, wk_rst_wdt = 0, wk_rst_bod = 0;
    logic clk_cpu_en, clk_io_en, clk_flash_en, clk_adc_en, osc_en, bod_en, adc_start, core_rst;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lowpwr_ctrl #(.STBY_CYC(STBY), .BOD_CYC(BODC)) u_lowpwr_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_sleep_en(cfg_sleep_en), .cfg_bod_off(cfg_bod_off), .sleep_req(sleep_req),
        .xtal_sel(xtal_sel), .adc_on(adc_on), .osc_ready(osc_ready),
        .wk_irq_int(wk_irq_int), .wk_irq_ext(wk_irq_ext), .wk_int0(wk_int0),
        .wk_pin_chg(wk_pin_chg), .wk_adc_done(wk_adc_done), .wk_nvm_rdy(wk_nvm_rdy),
        .wk_rst_ext(wk_rst_ext), .wk_rst_wdt(wk_rst_wdt), .wk_rst_bod(wk_rst_bod),
        .clk_cpu_en(clk_cpu_en), .clk_io_en(clk_io_en), .clk_flash_en(clk_flash_en),
        .clk_adc_en(clk_adc_en), .osc_en(osc_en), .bod_en(bod_en),
        .adc_start(adc_start), .core_rst(core_rst)
    );

    // Behavioural reference: phase 0 running, 1 asleep, 2 oscillator restart, 3 counting
    int m_ph, m_mode, m_cnt, c_mode;
    bit m_bod, m_as, m_cr, c_sen, c_bod;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_cnt = 0; m_bod = 0; m_as = 0; m_cr = 0;
            c_mode = 0; c_sen = 0; c_bod = 0;
        end else begin
            bit any_rst, hit;
            int eff;
            any_rst = wk_rst_ext | wk_rst_wdt | wk_rst_bod;
            if (m_mode == 0)
                hit = wk_irq_int | wk_irq_ext | wk_int0 | wk_pin_chg | wk_adc_done | wk_nvm_rdy | any_rst;
            else if (m_mode == 1)
                hit = wk_adc_done | wk_nvm_rdy | wk_int0 | wk_pin_chg | any_rst;
            else
                hit = wk_int0 | wk_pin_chg | any_rst;
            m_cr = (m_ph == 1) && any_rst;
            m_as = 0;
            if (m_ph == 0) begin
                if (sleep_req && c_sen) begin
                    eff = (c_mode == 3 && !xtal_sel) ? 2 : c_mode;
                    m_mode = eff;
                    m_bod = c_bod && (eff >= 2);
                    m_as = adc_on && (eff < 2);
                    m_ph = 1;
                end
            end else if (m_ph == 1) begin
                if (hit) begin
                    if (m_mode < 2) m_ph = 0;
                    else if (m_mode == 2) m_ph = 2;
                    else begin m_ph = 3; m_cnt = m_bod ? BODC : STBY; end
                end
            end else if (m_ph == 2) begin
                if (osc_ready) begin
                    if (m_bod) begin m_ph = 3; m_cnt = BODC; end
                    else m_ph = 0;
                end
            end else begin
                if (m_cnt == 1) m_ph = 0;
                else m_cnt = m_cnt - 1;
            end
            if (cfg_wr) begin
                c_mode = int'(cfg_mode); c_sen = cfg_sleep_en; c_bod = cfg_bod_off;
            end
        end
    end

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_cpu, e_io, e_fl, e_adc, e_osc, e_bod;
            string tag;
            e_cpu = 0; e_io = 0; e_fl = 0; e_adc = 0; e_osc = 1; e_bod = 1;
            tag = "R2";
            if (m_ph == 0) begin
                e_cpu = 1; e_io = 1; e_fl = 1; e_adc = 1;
            end else if (m_ph == 1) begin
                e_bod = !m_bod;
                case (m_mode)
                    0: begin e_io = 1; e_fl = 1; e_adc = 1; tag = "R3"; end
                    1: begin e_adc = 1; tag = "R4"; end
                    2: begin e_osc = 0; tag = "R6"; end
                    default: tag = "R8";
                endcase
            end else if (m_ph == 2) tag = "R7";
            else tag = m_bod ? "R11" : "R8";
            chk(clk_cpu_en, e_cpu, tag, "clk_cpu_en");
            chk(clk_io_en, e_io, tag, "clk_io_en");
            chk(clk_flash_en, e_fl, tag, "clk_flash_en");
            chk(clk_adc_en, e_adc, tag, "clk_adc_en");
            chk(osc_en, e_osc, tag, "osc_en");
            chk(bod_en, e_bod, "R10", "bod_en");
            chk(adc_start, m_as, "R5", "adc_start");
            chk(core_rst, m_cr, "R12", "core_rst");
        end
    end

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic do_cfg(input logic [1:0] md, input bit sen, input bit bod);
        step();
        cfg_mode = md; cfg_sleep_en = sen; cfg_bod_off = bod; cfg_wr = 1;
        step();
        cfg_wr = 0;
    endtask

    task automatic do_sleep();
        step(); sleep_req = 1; step(); sleep_req = 0;
    endtask

    // wake index: 0 irq_int 1 irq_ext 2 int0 3 pin_chg 4 adc_done 5 nvm_rdy 6 rst_ext 7 rst_wdt 8 rst_bod
    task automatic do_wake(input int w);
        step();
        case (w)
            0: wk_irq_int = 1; 1: wk_irq_ext = 1; 2: wk_int0 = 1; 3: wk_pin_chg = 1;
            4: wk_adc_done = 1; 5: wk_nvm_rdy = 1; 6: wk_rst_ext = 1; 7: wk_rst_wdt = 1;
            default: wk_rst_bod = 1;
        endcase
        step();
        {wk_irq_int, wk_irq_ext, wk_int0, wk_pin_chg, wk_adc_done, wk_nvm_rdy,
         wk_rst_ext, wk_rst_wdt, wk_rst_bod} = '0;
    endtask

    task automatic osc_up();
        step(); osc_ready = 1; step(); osc_ready = 0;
    endtask

    task automatic count_resume(output int n);
        n = 0;
        while (!clk_cpu_en && n < 5000) begin step(); n++; end
    endtask

    task automatic chk_int(input int act, input int exp, input string req, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        step();
        chk(clk_cpu_en, 1, "R1", "reset cpu");
        chk(osc_en & bod_en & clk_io_en & clk_flash_en & clk_adc_en, 1, "R1", "reset enables");
        chk(adc_start | core_rst, 0, "R1", "reset pulses");

        // R2: request without the permit bit does nothing
        do_cfg(2'b00, 0, 0);
        do_sleep();
        chk(clk_cpu_en, 1, "R2", "sleep without permit");

        // R3/R5: Idle with ADC on
        adc_on = 1;
        do_cfg(2'b00, 1, 0);
        do_sleep();
        chk(clk_cpu_en, 0, "R3", "idle cpu gated");
        chk(clk_io_en, 1, "R3", "idle io running");
        chk(adc_start, 1, "R5", "idle start pulse");
        step();
        chk(adc_start, 0, "R5", "start pulse single");
        do_wake(0);
        chk(clk_cpu_en, 1, "R3", "idle wake by internal irq");

        // R4/R5: ADC-quiet with ADC off
        adc_on = 0;
        do_cfg(2'b01, 1, 0);
        do_sleep();
        chk(adc_start, 0, "R5", "no start with adc off");
        chk(clk_io_en | clk_flash_en, 0, "R4", "adcq io/flash gated");
        chk(clk_adc_en, 1, "R4", "adcq adc running");
        do_wake(0);
        chk(clk_cpu_en, 0, "R4", "internal irq ignored");
        do_wake(1);
        chk(clk_cpu_en, 0, "R4", "ext irq ignored");
        do_wake(5);
        chk(clk_cpu_en, 1, "R4", "nvm ready wakes");

        // R6/R7: Power-down
        adc_on = 1;
        do_cfg(2'b10, 1, 0);
        do_sleep();
        chk(adc_start, 0, "R5", "no start in power-down");
        chk(osc_en, 0, "R6", "pd osc off");
        do_wake(4);
        chk(osc_en, 0, "R6", "adc done ignored in pd");
        do_wake(1);
        chk(osc_en, 0, "R6", "ext irq ignored in pd");
        do_wake(3);
        chk(osc_en, 1, "R7", "osc restarted");
        chk(clk_cpu_en, 0, "R7", "cpu waits for osc");
        step(); step(); step();
        chk(clk_cpu_en, 0, "R7", "cpu still waits");
        osc_up();
        chk(clk_cpu_en, 1, "R7", "cpu after osc ready");

        // R8: Standby with crystal
        xtal_sel = 1;
        do_cfg(2'b11, 1, 0);
        do_sleep();
        chk(osc_en, 1, "R8", "standby osc kept");
        chk(clk_cpu_en | clk_io_en, 0, "R8", "standby clocks off");
        do_wake(2);
        count_resume(n);
        chk_int(n, STBY, "R8", "standby resume cycles");

        // R9: Standby without crystal falls back
        xtal_sel = 0;
        do_cfg(2'b11, 1, 0);
        do_sleep();
        chk(osc_en, 0, "R9", "fallback osc off");
        do_wake(3);
        chk(clk_cpu_en, 0, "R9", "fallback waits osc");
        osc_up();
        chk(clk_cpu_en, 1, "R9", "fallback resume");

        // R10/R11/R12: Power-down, brown-out off, watchdog reset wake
        do_cfg(2'b10, 1, 1);
        do_sleep();
        chk(bod_en, 0, "R10", "bod off in pd");
        do_wake(7);
        chk(core_rst, 1, "R12", "wdt reset pulse");
        chk(bod_en, 1, "R10", "bod back on wake");
        step();
        chk(core_rst, 0, "R12", "reset pulse single");
        osc_up();
        count_resume(n);
        chk_int(n, BODC, "R11", "pd bod settle cycles");

        // R10/R12: Idle ignores brown-out off
        do_cfg(2'b00, 1, 1);
        do_sleep();
        chk(bod_en, 1, "R10", "bod on in idle");
        do_wake(2);
        chk(core_rst, 0, "R12", "irq wake no reset");
        chk(clk_cpu_en, 1, "R3", "idle int0 wake");

        // R11/R12: Standby, brown-out off, external reset wake
        xtal_sel = 1;
        do_cfg(2'b11, 1, 1);
        do_sleep();
        chk(bod_en, 0, "R10", "bod off in standby");
        do_wake(6);
        chk(core_rst, 1, "R12", "ext reset pulse");
        count_resume(n);
        chk_int(n, BODC, "R11", "standby bod settle cycles");

        // R12: brown-out reset wake from ADC-quiet
        do_cfg(2'b01, 1, 0);
        do_sleep();
        do_wake(8);
        chk(core_rst, 1, "R12", "bod reset pulse");
        chk(clk_cpu_en, 1, "R12", "bod reset wakes");

        step(); step();
        summary();
    end
endmodule